// File: doc/BRIEF.md
# Cipher-Based Self-Test Pattern Engine

This block is an iterative AES-128 encryption datapath. Besides plain block encryption it provides three test modes, and each of them reuses the same round loop. In pattern mode every ciphertext is encrypted again, so the loop produces a pseudorandom 128-bit stream that can drive other cores. In signature mode each 128-bit response from another core is folded into the running state and then encrypted, which compacts the responses into one signature. In self-test mode the core chains encryptions from a built-in seed and key and compares the last block with an expected value supplied from outside.

One round runs per clock. The round key is derived on the fly from the previous round key, so no expanded key schedule is stored. A run is started with a one-cycle `start_i` pulse. That edge captures the mode, the data, the key and the block count. Results appear on `block_o` with a one-cycle `valid_o` pulse, and the end of a run is marked by `done_o`.

Top module: `aes_tpg_engine`

## Requirements
- R1: After reset `busy_o`, `valid_o`, `done_o` and `pass_o` are low and `block_o` is zero.
- R2: With `mode_i` = 00 (encrypt), a start captures `data_i` and `key_i`. Ten clock edges after the capturing edge, `block_o` holds the AES-128 ciphertext, with `valid_o` and `done_o` high. Byte 0 of the block is bits 127:120, and bytes fill the state column by column, as in the standard (key 000102..0f, plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a).
- R3: `busy_o` is high from the capturing edge until the run ends. A `start_i` pulse while busy is ignored: it changes neither the mode, the data, the key nor the timing of the run in progress.
- R4: With `mode_i` = 01 (pattern), the core emits `count_i` blocks, one every 10 cycles. The first block is the encryption of `data_i`, and each following block is the encryption of the previous block under the same key. `done_o` is high with the last block.
- R5: A `count_i` of zero behaves as a count of one.
- R6: With `mode_i` = 10 (signature), a start loads `data_i` as the initial signature and emits nothing. Each `resp_valid_i` pulse while the core waits starts an encryption of (signature XOR `resp_data_i`). Ten edges later the result appears on `block_o` with `valid_o` and becomes the new signature. `done_o` is high after the `count_i`-th response.
- R7: In signature mode a `resp_valid_i` pulse that arrives while an encryption is running is ignored.
- R8: With `mode_i` = 11 (self-test), the core chains `count_i` encryptions from the SEED parameter under the SKEY parameter, with the same timing as R4. With the last block, `pass_o` goes high when that block equals `golden_i`, and it stays high until the next start.
- R9: In self-test mode `data_i` and `key_i` are ignored, and `pass_o` stays low when the final block differs from `golden_i`.
- R10: `done_o` and `valid_o` are one-cycle pulses. `block_o` keeps its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures mode, data, key, count when idle |
| mode_i | input | 2 | 00 encrypt, 01 pattern, 10 signature, 11 self-test |
| data_i | input | 128 | Plaintext, pattern seed or initial signature |
| key_i | input | 128 | Cipher key (unused in self-test) |
| count_i | input | CNT_W | Number of blocks or responses for a run |
| resp_valid_i | input | 1 | Response strobe in signature mode |
| resp_data_i | input | 128 | Response word to compact |
| golden_i | input | 128 | Expected final block in self-test |
| busy_o | output | 1 | Run in progress |
| valid_o | output | 1 | New result on block_o |
| block_o | output | 128 | Ciphertext, pattern or signature |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Self-test matched golden value |

## Verification
Because every output block feeds the next encryption, any wrong bit in the state, round key or round constant spreads through the whole block within one or two rounds. It then shows as a ciphertext mismatch at the first `valid_o` pulse, and every later chained block or signature differs as well. Faults in the control path show up instead as a `valid_o` or `done_o` pulse in the wrong cycle, or as a run whose length does not match `count_i`, and the per-cycle comparison against the expected pulse positions catches these. Ignored strobes are checked by confirming that the block and its timing come out exactly as they would without the strobe.

// File: rtl/aes_tpg_pkg.sv
package aes_tpg_pkg;
  localparam int unsigned BLK_W    = 128;
  localparam int unsigned N_ROUNDS = 10;

  typedef enum logic [1:0] {
    MODE_ENC  = 2'b00,
    MODE_PAT  = 2'b01,
    MODE_SIG  = 2'b10,
    MODE_BIST = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_WAIT = 2'b10
  } fsm_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mul3(input logic [7:0] a);
    return xtime(a) ^ a;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    p  = '0;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xtime(aa);
    end
    return p;
  endfunction

  // inverse as a^254 = a^2 * a^4 * ... * a^128
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] a_i,
  output logic [7:0] s_o
);
  assign s_o = aes_tpg_pkg::sbox(a_i);
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step (
  input  logic [127:0] rk_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] rk_o
);
  logic [31:0] w3_rot;
  logic [31:0] w3_sub;
  logic [31:0] t;
  logic [31:0] n0, n1, n2, n3;

  assign w3_rot = {rk_i[23:0], rk_i[31:24]};

  for (genvar i = 0; i < 4; i++) begin : g_sub
    aes_sbox u_sbox (.a_i(w3_rot[31-8*i -: 8]), .s_o(w3_sub[31-8*i -: 8]));
  end

  assign t  = w3_sub ^ {rcon_i, 24'h0};
  assign n0 = rk_i[127:96] ^ t;
  assign n1 = rk_i[95:64]  ^ n0;
  assign n2 = rk_i[63:32]  ^ n1;
  assign n3 = rk_i[31:0]   ^ n2;
  assign rk_o = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_round_step.sv
module aes_round_step (
  input  logic [127:0] state_i,
  input  logic [127:0] rkey_i,
  input  logic         last_i,
  output logic [127:0] state_o
);
  import aes_tpg_pkg::*;

  logic [7:0] sb [16];
  logic [7:0] sr [16];
  logic [7:0] mx [16];

  for (genvar b = 0; b < 16; b++) begin : g_sub
    aes_sbox u_sbox (.a_i(state_i[127-8*b -: 8]), .s_o(sb[b]));
  end

  // byte index = 4*col + row; row r rotates left by r
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sr[4*c+r] = sb[4*((c+r)%4)+r];
    end
    assign mx[4*c+0] = xtime(sr[4*c]) ^ mul3(sr[4*c+1]) ^ sr[4*c+2] ^ sr[4*c+3];
    assign mx[4*c+1] = sr[4*c] ^ xtime(sr[4*c+1]) ^ mul3(sr[4*c+2]) ^ sr[4*c+3];
    assign mx[4*c+2] = sr[4*c] ^ sr[4*c+1] ^ xtime(sr[4*c+2]) ^ mul3(sr[4*c+3]);
    assign mx[4*c+3] = mul3(sr[4*c]) ^ sr[4*c+1] ^ sr[4*c+2] ^ xtime(sr[4*c+3]);
  end

  for (genvar b = 0; b < 16; b++) begin : g_ark
    assign state_o[127-8*b -: 8] = (last_i ? sr[b] : mx[b]) ^ rkey_i[127-8*b -: 8];
  end
endmodule

// File: rtl/aes_tpg_engine.sv
module aes_tpg_engine #(
  parameter int unsigned  CNT_W = 16,
  parameter logic [127:0] SEED  = 128'h3c1e_a5f0_0f5a_e1c3_9b27_64d8_8d46_72b9,
  parameter logic [127:0] SKEY  = 128'h5a17_c3e9_28b4_d06f_7e91_4a2c_b5d3_18f6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [127:0]     data_i,
  input  logic [127:0]     key_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             resp_valid_i,
  input  logic [127:0]     resp_data_i,
  input  logic [127:0]     golden_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [127:0]     block_o,
  output logic             done_o,
  output logic             pass_o
);
  import aes_tpg_pkg::*;

  localparam int unsigned RND_W = $clog2(N_ROUNDS + 1);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(N_ROUNDS);

  fsm_e             fsm_q;
  mode_e            mode_q;
  logic [127:0]     st_q, rk_q, key_q, blk_q;
  logic [7:0]       rcon_q;
  logic [RND_W-1:0] rnd_q;
  logic [CNT_W-1:0] left_q;
  logic             valid_q, done_q, pass_q;

  logic [127:0] rk_nxt, st_nxt;
  logic         run_last, blk_end;

  aes_key_step u_key (
    .rk_i  (rk_q),
    .rcon_i(rcon_q),
    .rk_o  (rk_nxt)
  );

  aes_round_step u_round (
    .state_i(st_q),
    .rkey_i (rk_nxt),
    .last_i (rnd_q == RND_LAST),
    .state_o(st_nxt)
  );

  assign blk_end  = (fsm_q == ST_RUN) && (rnd_q == RND_LAST);
  assign run_last = (mode_q == MODE_ENC) || (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q   <= ST_IDLE;
      mode_q  <= MODE_ENC;
      st_q    <= '0;
      rk_q    <= '0;
      key_q   <= '0;
      blk_q   <= '0;
      rcon_q  <= 8'h01;
      rnd_q   <= '0;
      left_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (fsm_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_e'(mode_i);
          left_q <= (count_i == '0) ? '0 : count_i - 1'b1;
          pass_q <= 1'b0;
          rcon_q <= 8'h01;
          rnd_q  <= RND_W'(1);
          if (mode_e'(mode_i) == MODE_BIST) begin
            key_q <= SKEY;
            rk_q  <= SKEY;
            st_q  <= SEED ^ SKEY;
            fsm_q <= ST_RUN;
          end else if (mode_e'(mode_i) == MODE_SIG) begin
            key_q <= key_i;
            st_q  <= data_i;
            fsm_q <= ST_WAIT;
          end else begin
            key_q <= key_i;
            rk_q  <= key_i;
            st_q  <= data_i ^ key_i;
            fsm_q <= ST_RUN;
          end
        end
        ST_WAIT: if (resp_valid_i) begin
          st_q   <= st_q ^ resp_data_i ^ key_q;
          rk_q   <= key_q;
          rcon_q <= 8'h01;
          rnd_q  <= RND_W'(1);
          fsm_q  <= ST_RUN;
        end
        ST_RUN: begin
          rk_q   <= rk_nxt;
          rcon_q <= xtime(rcon_q);
          rnd_q  <= rnd_q + 1'b1;
          st_q   <= st_nxt;
          if (blk_end) begin
            blk_q   <= st_nxt;
            valid_q <= 1'b1;
            if (run_last) begin
              fsm_q  <= ST_IDLE;
              done_q <= 1'b1;
              if (mode_q == MODE_BIST) pass_q <= (st_nxt == golden_i);
            end else begin
              left_q <= left_q - 1'b1;
              if (mode_q == MODE_SIG) begin
                fsm_q <= ST_WAIT;
              end else begin
                // chain: ciphertext becomes next plaintext
                st_q   <= st_nxt ^ key_q;
                rk_q   <= key_q;
                rcon_q <= 8'h01;
                rnd_q  <= RND_W'(1);
              end
            end
          end
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (fsm_q != ST_IDLE);
  assign valid_o = valid_q;
  assign block_o = blk_q;
  assign done_o  = done_q;
  assign pass_o  = pass_q;

  // R10
  done_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  // R3
  valid_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(fsm_q == ST_RUN));

  // R3
  round_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == ST_RUN) |-> (rnd_q >= RND_W'(1) && rnd_q <= RND_LAST));

  // R2
  first_rcon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == ST_RUN && rnd_q == RND_W'(1)) |-> (rcon_q == 8'h01));

  // R8
  pass_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> done_o);
endmodule

// File: tb/aes_tpg_engine_test.sv
`timescale 1ns/1ps
module aes_tpg_engine_test;
  localparam logic [127:0] T_SEED = 128'h3c1e_a5f0_0f5a_e1c3_9b27_64d8_8d46_72b9;
  localparam logic [127:0] T_SKEY = 128'h5a17_c3e9_28b4_d06f_7e91_4a2c_b5d3_18f6;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   mode_i = '0;
  logic [127:0] data_i = '0, key_i = '0, resp_data_i = '0, golden_i = '0;
  logic [15:0]  count_i = '0;
  logic         resp_valid_i = 1'b0;
  logic         busy_o, valid_o, done_o, pass_o;
  logic [127:0] block_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] sbt [256];

  always #5 clk = ~clk;

  aes_tpg_engine #(.CNT_W(16), .SEED(T_SEED), .SKEY(T_SKEY)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .data_i(data_i), .key_i(key_i), .count_i(count_i),
    .resp_valid_i(resp_valid_i), .resp_data_i(resp_data_i), .golden_i(golden_i),
    .busy_o(busy_o), .valid_o(valid_o), .block_o(block_o), .done_o(done_o), .pass_o(pass_o)
  );

  function automatic logic [7:0] dbl(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x = a, y = b, p = 0;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = dbl(x);
      y = y >> 1;
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0;
      logic [7:0] o;
      for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sbt[x] = o;
    end
  endtask

  function automatic logic [127:0] aes_ref(input logic [127:0] pt, input logic [127:0] k);
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [31:0] w [44];
    logic [31:0] tmp;
    logic [7:0]  rc = 8'h01;
    logic [127:0] out;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sbt[tmp[23:16]], sbt[tmp[15:8]], sbt[tmp[7:0]], sbt[tmp[31:24]]} ^ {rc, 24'h0};
        rc = dbl(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) t[i] = sbt[s[i]];
      for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
      if (rd != 10) begin
        for (int c = 0; c < 4; c++) begin
          t[4*c]   = gm(s[4*c],2) ^ gm(s[4*c+1],3) ^ s[4*c+2] ^ s[4*c+3];
          t[4*c+1] = s[4*c] ^ gm(s[4*c+1],2) ^ gm(s[4*c+2],3) ^ s[4*c+3];
          t[4*c+2] = s[4*c] ^ s[4*c+1] ^ gm(s[4*c+2],2) ^ gm(s[4*c+3],3);
          t[4*c+3] = gm(s[4*c],3) ^ s[4*c+1] ^ s[4*c+2] ^ gm(s[4*c+3],2);
        end
        for (int i = 0; i < 16; i++) s[i] = t[i];
      end
      for (int i = 0; i < 16; i++) s[i] ^= w[4*rd + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
    return out;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_run(input logic [1:0] m, input logic [127:0] d, input logic [127:0] k, input int cnt);
    @(negedge clk);
    start_i = 1; mode_i = m; data_i = d; key_i = k; count_i = 16'(cnt);
    @(posedge clk); #1;
    start_i = 0;
  endtask

  task automatic send_resp(input logic [127:0] r);
    @(negedge clk);
    resp_valid_i = 1; resp_data_i = r;
    @(posedge clk); #1;
    resp_valid_i = 0;
  endtask

  // nz quiet cycles, then result; poke>0 injects start/resp at that quiet cycle
  task automatic expect_block(input int nz, input logic [127:0] exp, input bit exp_done,
                              input int poke, input string req);
    for (int i = 1; i <= nz; i++) begin
      @(negedge clk);
      chk(valid_o == 0 && busy_o == 1, {req, " quiet/busy"}, {126'b0, valid_o, busy_o}, 128'h1);
      if (i == poke) begin
        start_i = 1; mode_i = 2'b00; data_i = ~exp; key_i = exp;
        resp_valid_i = 1; resp_data_i = 128'hdead_beef;
      end else if (i == poke + 1) begin
        start_i = 0; resp_valid_i = 0;
      end
    end
    @(negedge clk);
    chk(valid_o == 1, {req, " valid"}, 128'(valid_o), 128'h1);
    chk(block_o == exp, {req, " block"}, block_o, exp);
    chk(done_o == exp_done, {req, " done"}, 128'(done_o), 128'(exp_done));
    if (exp_done) chk(busy_o == 0, {req, " busy end"}, 128'(busy_o), 128'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] k, d, b, g, sig;
    build_sbox();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(busy_o == 0 && valid_o == 0 && done_o == 0 && pass_o == 0, "R1 flags",
        {124'b0, busy_o, valid_o, done_o, pass_o}, 128'h0);
    chk(block_o == 0, "R1 block", block_o, 128'h0);
    rst_ni = 1;

    // R2: standard vector through reference and core
    k = 128'h000102030405060708090a0b0c0d0e0f;
    d = 128'h00112233445566778899aabbccddeeff;
    chk(aes_ref(d, k) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 reference",
        aes_ref(d, k), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    start_run(2'b00, d, k, 0);
    expect_block(10, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1, 0, "R2 enc std");
    // R10: pulses drop, block holds
    @(negedge clk);
    chk(valid_o == 0 && done_o == 0, "R10 pulse", {126'b0, valid_o, done_o}, 128'h0);
    chk(block_o == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R10 hold", block_o,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R2, R3: second vector, start pulse while busy ignored
    k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    d = 128'h3243f6a8885a308d313198a2e0370734;
    start_run(2'b00, d, k, 5);
    expect_block(10, aes_ref(d, k), 1, 3, "R3 enc busy start");
    k = 128'hffff_0000_1234_5678_9abc_def0_0f1e_2d3c;
    d = 128'h0;
    start_run(2'b00, d, k, 0);
    expect_block(10, aes_ref(d, k), 1, 0, "R2 enc zero pt");

    // R4: pattern chain of 4
    k = 128'h0f0e0d0c0b0a09080706050403020100;
    d = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    start_run(2'b01, d, k, 4);
    b = d;
    for (int i = 0; i < 4; i++) begin
      b = aes_ref(b, k);
      expect_block(i == 0 ? 10 : 9, b, i == 3, i == 1 ? 4 : 0, "R4 pattern");
    end

    // R5: zero count acts as one
    start_run(2'b01, d, k, 0);
    expect_block(10, aes_ref(d, k), 1, 0, "R5 count zero");

    // R6, R7: signature over two responses
    k = 128'hcafe_f00d_0123_4567_89ab_cdef_fedc_ba98;
    sig = 128'h5555_aaaa_5555_aaaa_0000_ffff_1234_4321;
    start_run(2'b10, sig, k, 2);
    @(negedge clk);
    chk(busy_o == 1 && valid_o == 0, "R6 load silent", {126'b0, busy_o, valid_o}, 128'h2);
    send_resp(128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10);
    sig = aes_ref(sig ^ 128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10, k);
    expect_block(10, sig, 0, 3, "R7 sig resp ignored");
    repeat (3) begin
      @(negedge clk);
      chk(valid_o == 0 && busy_o == 1, "R6 wait", {126'b0, valid_o, busy_o}, 128'h1);
    end
    send_resp(128'hfedc_ba98_7654_3210_0f0f_f0f0_a5a5_5a5a);
    sig = aes_ref(sig ^ 128'hfedc_ba98_7654_3210_0f0f_f0f0_a5a5_5a5a, k);
    expect_block(10, sig, 1, 0, "R6 sig final");

    // R8: self-test pass
    g = T_SEED;
    for (int i = 0; i < 3; i++) g = aes_ref(g, T_SKEY);
    golden_i = g;
    start_run(2'b11, 128'h1234, 128'h5678, 3);
    b = T_SEED;
    for (int i = 0; i < 3; i++) begin
      b = aes_ref(b, T_SKEY);
      expect_block(i == 0 ? 10 : 9, b, i == 2, 0, "R8 selftest");
    end
    chk(pass_o == 1, "R8 pass", 128'(pass_o), 128'h1);
    @(negedge clk);
    chk(pass_o == 1, "R8 pass held", 128'(pass_o), 128'h1);

    // R9: data/key ignored, mismatch gives no pass
    g = aes_ref(aes_ref(T_SEED, T_SKEY), T_SKEY);
    golden_i = g ^ 128'h1;
    start_run(2'b11, ~T_SEED, ~T_SKEY, 2);
    expect_block(10, aes_ref(T_SEED, T_SKEY), 0, 0, "R9 selftest");
    expect_block(9, g, 1, 0, "R9 selftest");
    chk(pass_o == 0, "R9 fail", 128'(pass_o), 128'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule